// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block manages one delayed read that a bridge forwards to a target on behalf of a requesting initiator. After it accepts a request, it launches read attempts toward the target one at a time. When an attempt ends in a retry, or ends without moving any data, it launches another attempt. It stops when data moves, when either kind of abort is seen, or when a parameterised number of retried attempts has been used up.

It then classifies the result and holds it as a pending completion. The completion carries a status (data, master abort, target abort or timeout) and the termination to give back to the initiator. That termination is a disconnect or a normal end, chosen from the prefetch attribute of the read and from how many data phases the initiator asked for compared with how many were fetched. The completion stays in place until the initiator's repeated request consumes it. No new read is accepted while an attempt is in progress or a completion is pending.

The bus protocol and the data storage are outside this block. Attempt outcomes arrive as a termination code together with a count of data phases.

Top module: `dread_retry_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `att_req`, `cpl_ready` and `err_pulse` are 0.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) makes `att_req` high for exactly one cycle in the following cycle. No further attempt is launched until `att_done` reports the end of that attempt.
- R3: Attempt termination codes are: 0 normal, 1 target retry, 2 target disconnect, 3 master abort, 4 target abort. Code 1, or code 0 or 2 with zero data phases, counts as a retried attempt. A retried attempt that leaves budget makes `att_req` pulse in the cycle after `att_done`.
- R4: Code 3 ends the read with `cpl_status` = 1 (master abort) and `cpl_disc` = 0.
- R5: Code 4 ends the read with `cpl_status` = 2 (target abort) and `cpl_disc` = 0.
- R6: Code 0 or 2 with at least one data phase ends the read with `cpl_status` = 0. For a non-prefetchable read, `cpl_disc` is then 1 whatever the counts.
- R7: For a prefetchable read ending with code 0 and data, `cpl_disc` is 1 exactly when the requested phase count exceeds the transferred count.
- R8: For a prefetchable read ending with code 2 and data, `cpl_disc` is 1 exactly when the requested phase count exceeds the transferred count.
- R9: When the RETRY_LIMIT-th retried attempt of one request ends, the read ends with `cpl_status` = 3 (timeout) and `cpl_disc` = 0. `err_pulse` is high for one cycle, in the first cycle of that completion. The retry count restarts at zero for every accepted request.
- R10: The completion appears on `cpl_ready` in the cycle after the final `att_done`. Status and termination are held until a cycle with `cpl_take` high, and `req_ready` returns one cycle after that. While not idle, `req_ready` is 0 and `req_valid` is ignored. `att_done` is ignored outside the wait for an attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Initiator presents a new delayed read |
| req_pf | input | 1 | Read targets prefetchable space |
| req_phases | input | PH_W | Data phases the initiator wants |
| req_ready | output | 1 | Block idle, request can be taken |
| att_req | output | 1 | One-cycle pulse launching a target attempt |
| att_done | input | 1 | Current attempt has ended |
| att_term | input | 3 | Termination code of the ended attempt |
| att_xfers | input | PH_W | Data phases moved by the ended attempt |
| cpl_ready | output | 1 | Completion pending for the initiator |
| cpl_status | output | 2 | 0 data, 1 master abort, 2 target abort, 3 timeout |
| cpl_disc | output | 1 | 1: return disconnect to initiator |
| cpl_take | input | 1 | Initiator retry consumes the completion |
| err_pulse | output | 1 | One-cycle flag on retry-limit timeout |

## Verification
A wrong attempt count shows at the ports as a timeout that comes one attempt early or late. It also shows as a timeout on a fresh request that should have had a full budget. The error appears in the cycle after the deciding `att_done`. A wrong state shows within one cycle: a missing or doubled `att_req` pulse, `req_ready` high while a completion is pending, or a completion that drops before `cpl_take`. A wrong termination choice appears on `cpl_disc` in the first completion cycle. The reference model is compared against every output on every clock, so any of these shows up in the cycle where it first occurs.

// File: rtl/dread_pkg.sv
package dread_pkg;

  localparam logic [2:0] TERM_NORMAL = 3'd0;
  localparam logic [2:0] TERM_RETRY  = 3'd1;
  localparam logic [2:0] TERM_DISC   = 3'd2;
  localparam logic [2:0] TERM_MABORT = 3'd3;
  localparam logic [2:0] TERM_TABORT = 3'd4;

  typedef enum logic [1:0] {
    CPL_DATA    = 2'd0,
    CPL_MABORT  = 2'd1,
    CPL_TABORT  = 2'd2,
    CPL_TIMEOUT = 2'd3
  } cpl_status_e;

  typedef enum logic [1:0] {
    K_RETRY, K_DATA, K_MABORT, K_TABORT
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE
  } dr_state_e;

  // Classify one attempt; data-free normal/disconnect behaves as a retry.
  function automatic outcome_e classify(input logic [2:0] term, input logic moved);
    case (term)
      TERM_MABORT: return K_MABORT;
      TERM_TABORT: return K_TABORT;
      TERM_NORMAL,
      TERM_DISC:   return moved ? K_DATA : K_RETRY;
      default:     return K_RETRY;
    endcase
  endfunction

  // Termination for the initiator after data was fetched.
  function automatic logic want_disc(input logic pf, input int unsigned asked,
                                     input int unsigned got);
    return !pf || (asked > got);
  endfunction

endpackage

// File: rtl/dread_outcome.sv
module dread_outcome
  import dread_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic [2:0]      term,
  input  logic [PH_W-1:0] xfers,
  input  logic            pf,
  input  logic [PH_W-1:0] asked,
  output outcome_e        kind,
  output logic            disc
);

  logic moved;
  assign moved = (xfers != '0);
  assign kind  = classify(term, moved);
  assign disc  = (kind == K_DATA) &&
                 want_disc(pf, int'(unsigned'(asked)), int'(unsigned'(xfers)));

endmodule

// File: rtl/dread_attempt_ctr.sv
module dread_attempt_ctr #(
  parameter int RETRY_LIMIT = 1 << 24,
  localparam int CNT_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_LIMIT - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_last);  // R9

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));  // R9

endmodule

// File: rtl/dread_retry_ctrl.sv
module dread_retry_ctrl
  import dread_pkg::*;
#(
  parameter int RETRY_LIMIT = 1 << 24,
  parameter int PH_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_pf,
  input  logic [PH_W-1:0] req_phases,
  output logic            req_ready,
  output logic            att_req,
  input  logic            att_done,
  input  logic [2:0]      att_term,
  input  logic [PH_W-1:0] att_xfers,
  output logic            cpl_ready,
  output logic [1:0]      cpl_status,
  output logic            cpl_disc,
  input  logic            cpl_take,
  output logic            err_pulse
);

  localparam int CNT_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;

  dr_state_e       state_q;
  logic            pf_q;
  logic [PH_W-1:0] asked_q;
  cpl_status_e     status_q;
  logic            disc_q;
  logic            err_q;

  // named internal events
  logic       accept, attempt_end, end_retry, end_final, to_timeout;
  logic       at_last, cnt_inc;
  logic [CNT_W-1:0] retry_cnt;
  outcome_e   kind;
  logic       kind_disc;

  dread_outcome #(.PH_W(PH_W)) u_outcome (
    .term  (att_term),
    .xfers (att_xfers),
    .pf    (pf_q),
    .asked (asked_q),
    .kind  (kind),
    .disc  (kind_disc)
  );

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign attempt_end = (state_q == ST_WAIT) && att_done;
  assign end_retry   = attempt_end && (kind == K_RETRY);
  assign to_timeout  = end_retry && at_last;
  assign end_final   = attempt_end && ((kind != K_RETRY) || at_last);
  assign cnt_inc     = end_retry && !at_last;

  dread_attempt_ctr #(.RETRY_LIMIT(RETRY_LIMIT)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .inc     (cnt_inc),
    .cnt     (retry_cnt),
    .at_last (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pf_q     <= 1'b0;
      asked_q  <= '0;
      status_q <= CPL_DATA;
      disc_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ISSUE;
          pf_q    <= req_pf;
          asked_q <= req_phases;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (attempt_end) begin
          if (to_timeout) begin
            state_q  <= ST_DONE;
            status_q <= CPL_TIMEOUT;
            disc_q   <= 1'b0;
            err_q    <= 1'b1;
          end else if (end_retry) begin
            state_q <= ST_ISSUE;
          end else begin
            state_q  <= ST_DONE;
            disc_q   <= kind_disc;
            case (kind)
              K_MABORT: status_q <= CPL_MABORT;
              K_TABORT: status_q <= CPL_TABORT;
              default:  status_q <= CPL_DATA;
            endcase
          end
        end
        ST_DONE: if (cpl_take) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign att_req    = (state_q == ST_ISSUE);
  assign cpl_ready  = (state_q == ST_DONE);
  assign cpl_status = status_q;
  assign cpl_disc   = disc_q;
  assign err_pulse  = err_q;

  AST_ATT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    att_req |=> !att_req);  // R2

  AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> att_req);  // R2

  AST_RETRY_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (end_retry && !at_last) |=> att_req);  // R3

  AST_FINAL_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    end_final |=> cpl_ready);  // R10

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_ready || att_req) |-> !req_ready);  // R10

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_ready && !cpl_take) |=>
      (cpl_ready && $stable(cpl_status) && $stable(cpl_disc)));  // R10

  AST_ABORT_NODISC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_ready && (cpl_status != 2'd0)) |-> !cpl_disc);  // R4

  AST_ERR_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (cpl_ready && (cpl_status == 2'd3)));  // R9

  AST_ERR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);  // R9

endmodule

// File: tb/tb_dread_retry_ctrl.sv
`timescale 1ns/1ps
module tb_dread_retry_ctrl;

  localparam int LIM  = 4;
  localparam int PH_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_pf = 0, att_done = 0, cpl_take = 0;
  logic [PH_W-1:0] req_phases = '0, att_xfers = '0;
  logic [2:0] att_term = '0;
  logic req_ready, att_req, cpl_ready, cpl_disc, err_pulse;
  logic [1:0] cpl_status;

  always #2 clk = ~clk;

  dread_retry_ctrl #(.RETRY_LIMIT(LIM), .PH_W(PH_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pf(req_pf), .req_phases(req_phases),
    .req_ready(req_ready), .att_req(att_req),
    .att_done(att_done), .att_term(att_term), .att_xfers(att_xfers),
    .cpl_ready(cpl_ready), .cpl_status(cpl_status), .cpl_disc(cpl_disc),
    .cpl_take(cpl_take), .err_pulse(err_pulse)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference: phase 0 idle, 1 launching, 2 awaiting, 3 holding
  int m_phase = 0, m_tries = 0, m_asked = 0, m_status = 0;
  bit m_pf = 0, m_disc = 0, m_err = 0;

  task automatic model_edge();
    m_err = 0;
    if (m_phase == 0) begin
      if (req_valid) begin
        m_phase = 1; m_tries = 0; m_pf = req_pf; m_asked = int'(req_phases);
      end
    end else if (m_phase == 1) begin
      m_phase = 2;
    end else if (m_phase == 2) begin
      if (att_done) begin
        if (att_term == 3) begin m_status = 1; m_disc = 0; m_phase = 3; end
        else if (att_term == 4) begin m_status = 2; m_disc = 0; m_phase = 3; end
        else if ((att_term == 0 || att_term == 2) && att_xfers != 0) begin
          m_status = 0; m_phase = 3;
          m_disc = !m_pf || (m_asked > int'(att_xfers));
        end else begin
          m_tries++;
          if (m_tries >= LIM) begin
            m_status = 3; m_disc = 0; m_err = 1; m_phase = 3;
          end else m_phase = 1;
        end
      end
    end else if (cpl_take) m_phase = 0;
  endtask

  task automatic check(string tag);
    bit ok;
    ok = (req_ready == (m_phase == 0)) && (att_req == (m_phase == 1)) &&
         (cpl_ready == (m_phase == 3)) && (err_pulse == m_err);
    if (m_phase == 3) ok = ok && (int'(cpl_status) == m_status) && (cpl_disc == m_disc);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got rdy=%0b att=%0b cpl=%0b st=%0d disc=%0b err=%0b exp rdy=%0b att=%0b cpl=%0b st=%0d disc=%0b err=%0b",
        tag, req_ready, att_req, cpl_ready, cpl_status, cpl_disc, err_pulse,
        m_phase == 0, m_phase == 1, m_phase == 3, m_status, m_disc, m_err);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    #1;
    check(tag);
  endtask

  task automatic request(bit pf, int n, string tag);
    req_valid = 1; req_pf = pf; req_phases = PH_W'(n);
    cyc(tag);
    req_valid = 0;
  endtask

  task automatic attempt(int term, int x, string tag);
    while (m_phase != 2) cyc(tag);
    att_done = 1; att_term = 3'(term); att_xfers = PH_W'(x);
    cyc(tag);
    att_done = 0; att_xfers = '0; att_term = '0;
  endtask

  task automatic take(string tag);
    while (m_phase != 3) cyc(tag);
    cyc(tag); cyc(tag);
    cpl_take = 1;
    cyc(tag);
    cpl_take = 0;
    cyc(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    rst_n = 1;
    cyc("R1");

    // R2/R3/R6: non-prefetchable, two retries then data
    request(0, 4, "R2");
    attempt(1, 0, "R3");
    attempt(0, 0, "R3");
    attempt(2, 3, "R6");
    take("R6");

    // R7: prefetchable normal, exact and short fetch
    request(1, 4, "R7"); attempt(0, 4, "R7"); take("R7");
    request(1, 5, "R7"); attempt(0, 3, "R7"); take("R7");
    // R6: non-prefetchable with all data still disconnects
    request(0, 1, "R6"); attempt(0, 1, "R6"); take("R6");

    // R8: prefetchable disconnect
    request(1, 2, "R8"); attempt(2, 2, "R8"); take("R8");
    request(1, 6, "R8"); attempt(1, 0, "R8"); attempt(2, 2, "R8"); take("R8");

    // R4, R5: aborts
    request(0, 3, "R4"); attempt(3, 0, "R4"); take("R4");
    request(1, 3, "R5"); attempt(1, 0, "R5"); attempt(4, 2, "R5"); take("R5");

    // R9: timeout after LIM retries, then fresh budget
    request(1, 2, "R9");
    for (int i = 0; i < LIM; i++) attempt(1, 0, "R9");
    take("R9");
    request(1, 2, "R9");
    for (int i = 0; i < LIM - 1; i++) attempt(2, 0, "R9");
    attempt(0, 2, "R9");
    take("R9");

    // R10: stray inputs ignored while busy or pending
    request(0, 2, "R10");
    att_done = 1; att_term = 3'd3;
    cyc("R10");
    att_done = 0; att_term = '0;
    attempt(0, 1, "R10");
    req_valid = 1; req_pf = 1; req_phases = 8'd9;
    att_done = 1; att_term = 3'd4;
    for (int i = 0; i < 5; i++) cyc("R10");
    req_valid = 0; att_done = 0; att_term = '0;
    take("R10");
    cyc("R1");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        checks++; fails++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

endmodule